// File: doc/BRIEF.md
# Four-master external bus arbiter

This block decides which of four requesters drives a shared external memory bus. The requesters are an off-chip device, a CPU port, a debug/trace port and a DMA transfer controller. The chip owns the bus by default. It gives the bus to the off-chip device only while that device holds its request line, and it confirms the release with an acknowledge output. The three on-chip requesters each use a request/grant/done handshake: a requester holds its request until it sees its grant, and the owner pulses done for one cycle to end its access.

Ownership changes only at access boundaries, meaning the edge that samples the owner's done pulse, or the edge that samples the off-chip request going low. Priority is fixed, with two adjustments:
- The CPU is never granted twice in a row while the debug or DMA port is waiting.
- A DMA request that arrives before a debug request during a CPU access is served ahead of the debug request.

A programmable idle gap of 0, 1, 2 or 4 bus-clock cycles separates one access from the next.

Top module: `ebus_arbiter`

## Requirements
- R1: During reset and in the first cycle after reset, no grant is active and `ext_ack_o` is low. The idle gap counter and the arrival-order flag also start cleared, so debug outranks DMA at the first decision.
- R2: When several requesters ask at one decision point, the winner follows a fixed order: off-chip device, then CPU, then debug, then DMA. On `int_req_i`, `int_gnt_o` and `int_done_i`, bit 0 is the CPU, bit 1 is the debug port and bit 2 is the DMA controller. From an idle bus the grant appears on the clock edge after the request is sampled.
- R3: The combined vector `{int_gnt_o, ext_ack_o}` is always one-hot or all-zero.
- R4: A grant stays unchanged until its owner ends the access. An on-chip owner ends it with its `int_done_i` bit. The off-chip device ends it by dropping `ext_req_i`. Done pulses from requesters that do not own the bus have no effect.
- R5: `ext_ack_o` rises only at an access boundary or from an idle bus, and only while `ext_req_i` is high. While `ext_ack_o` is high, all of `int_gnt_o` is low. `ext_ack_o` stays high for as long as `ext_req_i` stays high.
- R6: When the CPU ends an access while the debug or DMA port is requesting, the next grant does not go to the CPU.
- R7: During a CPU access, if a DMA request appears in an earlier cycle than a debug request, DMA is granted first when the CPU access ends. If the debug request appears first, or both appear in the same cycle, debug is granted first. The order record is cleared whenever a grant is issued.
- R8: `gap_sel_i` selects the idle gap between the end of one access and the next grant: 0 gives 0 cycles, 1 gives 1, 2 gives 2 and 3 gives 4. The setting is taken in the cycle where the access ends. During the gap, all grants are low for exactly that many cycles.
- R9: With a gap of 0, the next grant appears on the same edge that samples the ending done pulse. No idle cycle is inserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_req_i | input | 1 | Off-chip device bus request; held high for its whole tenure |
| ext_ack_o | output | 1 | Bus released to the off-chip device |
| int_req_i | input | 3 | On-chip requests: bit 0 CPU, bit 1 debug, bit 2 DMA |
| int_gnt_o | output | 3 | On-chip grants, same bit order |
| int_done_i | input | 3 | One-cycle end-of-access pulses from the owner, same bit order |
| gap_sel_i | input | 2 | Idle gap setting (0, 1, 2 or 4 cycles) |

## Verification
The priority order is tried from an idle bus with single, paired and full request sets. Adding the off-chip request to a full set separates the top level from the CPU level.

Three sequences cover the CPU rules and the order record:
- The CPU and debug port both request continuously, which shows that the CPU yields and then gets the bus back.
- DMA is raised before debug during a CPU access.
- Debug is raised before DMA during a CPU access.

The last two sequences show that the order record, not the fixed rank, decides the outcome. Each gap setting is measured by counting grant-free cycles after a done pulse. Stray done pulses from non-owners and an off-chip request raised in the middle of an access confirm that ownership changes only at a boundary.

// File: rtl/ebus_arb_pkg.sv
package ebus_arb_pkg;
  localparam int NUM_MST = 4;
  localparam int NUM_INT = NUM_MST - 1;
  localparam int IDX_EXT = 0;
  localparam int IDX_CPU = 1;
  localparam int IDX_DBG = 2;
  localparam int IDX_DMA = 3;

  typedef logic [NUM_MST-1:0] mst_vec_t;

  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_BUSY = 2'd1,
    ARB_GAP  = 2'd2
  } arb_state_e;
endpackage

// File: rtl/ebus_arb_pick.sv
// Combinational winner selection over the four masters.
module ebus_arb_pick
  import ebus_arb_pkg::*;
(
  input  mst_vec_t req_i,
  input  logic     cpu_last_i,
  input  logic     dma_first_i,
  output mst_vec_t win_o,
  output logic     any_o
);
  logic lower_wait;
  logic cpu_ok;
  logic dbg_ok;

  always_comb begin
    lower_wait = req_i[IDX_DBG] | req_i[IDX_DMA];
    cpu_ok     = req_i[IDX_CPU] & ~(cpu_last_i & lower_wait);
    dbg_ok     = req_i[IDX_DBG] & ~(req_i[IDX_DMA] & dma_first_i);
    any_o      = |req_i;
    win_o      = '0;
    if (req_i[IDX_EXT])      win_o[IDX_EXT] = 1'b1;
    else if (cpu_ok)         win_o[IDX_CPU] = 1'b1;
    else if (dbg_ok)         win_o[IDX_DBG] = 1'b1;
    else if (req_i[IDX_DMA]) win_o[IDX_DMA] = 1'b1;
    else if (req_i[IDX_CPU]) win_o[IDX_CPU] = 1'b1;
  end
endmodule

// File: rtl/ebus_arb_gap.sv
// Idle gap down-counter; loaded when an access ends.
module ebus_arb_gap #(
  parameter  int IDLE_MAX = 4,
  parameter  int SEL_W    = 2,
  localparam int CNT_W    = $clog2(IDLE_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             zero_len_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic [CNT_W-1:0] len;

  function automatic logic [CNT_W-1:0] gap_len(input logic [SEL_W-1:0] s);
    if (&s) return CNT_W'(IDLE_MAX);
    else    return CNT_W'(s);
  endfunction

  always_comb begin
    len        = gap_len(sel_i);
    zero_len_o = (len == '0);
    last_o     = (cnt_q == CNT_W'(1));
    cnt_en     = load_i | (cnt_q != '0);
    cnt_d      = load_i ? len : (cnt_q - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ebus_arb_order.sv
// One-bit record: DMA request seen before debug request during a CPU tenure.
module ebus_arb_order (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_own_i,
  input  logic dbg_req_i,
  input  logic dma_req_i,
  input  logic clr_i,
  output logic dma_first_o
);
  logic flag_q, flag_d, flag_en;

  always_comb begin
    flag_en = clr_i | (cpu_own_i & dma_req_i & ~dbg_req_i);
    flag_d  = ~clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign dma_first_o = flag_q;
endmodule

// File: rtl/ebus_arbiter.sv
module ebus_arbiter
  import ebus_arb_pkg::*;
#(
  parameter int IDLE_MAX = 4,
  parameter int SEL_W    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ext_req_i,
  output logic               ext_ack_o,
  input  logic [NUM_INT-1:0] int_req_i,
  output logic [NUM_INT-1:0] int_gnt_o,
  input  logic [NUM_INT-1:0] int_done_i,
  input  logic [SEL_W-1:0]   gap_sel_i
);
  arb_state_e state_q, state_d;
  mst_vec_t   gnt_q, gnt_d;
  logic       cpu_last_q, cpu_last_d;
  logic       reg_en;

  mst_vec_t   req_all, done_all, win;
  logic       any_req, release_now, issue, gap_load;
  logic       gap_zero, gap_last, dma_first;

  // Gather per-master request and end-of-access signals.
  assign req_all[IDX_EXT]  = ext_req_i;
  assign done_all[IDX_EXT] = ~ext_req_i;
  for (genvar g = 0; g < NUM_INT; g++) begin : g_int
    assign req_all[g+1]  = int_req_i[g];
    assign done_all[g+1] = int_done_i[g];
  end

  ebus_arb_pick u_pick (
    .req_i       (req_all),
    .cpu_last_i  (cpu_last_q),
    .dma_first_i (dma_first),
    .win_o       (win),
    .any_o       (any_req)
  );

  ebus_arb_gap #(.IDLE_MAX(IDLE_MAX), .SEL_W(SEL_W)) u_gap (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (gap_load),
    .sel_i      (gap_sel_i),
    .zero_len_o (gap_zero),
    .last_o     (gap_last)
  );

  ebus_arb_order u_order (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_own_i   (gnt_q[IDX_CPU]),
    .dbg_req_i   (int_req_i[IDX_DBG-1]),
    .dma_req_i   (int_req_i[IDX_DMA-1]),
    .clr_i       (issue),
    .dma_first_o (dma_first)
  );

  // Next-state logic.
  always_comb begin
    release_now = (state_q == ARB_BUSY) && (|(gnt_q & done_all));
    issue       = 1'b0;
    gap_load    = 1'b0;
    state_d     = state_q;
    gnt_d       = gnt_q;
    unique case (state_q)
      ARB_IDLE: begin
        if (any_req) issue = 1'b1;
      end
      ARB_BUSY: begin
        if (release_now) begin
          gnt_d = '0;
          if (!gap_zero) begin
            gap_load = 1'b1;
            state_d  = ARB_GAP;
          end else if (any_req) begin
            issue = 1'b1;
          end else begin
            state_d = ARB_IDLE;
          end
        end
      end
      ARB_GAP: begin
        if (gap_last) begin
          if (any_req) issue = 1'b1;
          else         state_d = ARB_IDLE;
        end
      end
      default: state_d = ARB_IDLE;
    endcase
    if (issue) begin
      gnt_d   = win;
      state_d = ARB_BUSY;
    end
    cpu_last_d = issue ? win[IDX_CPU] : cpu_last_q;
    reg_en     = issue | release_now | (state_d != state_q);
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ARB_IDLE;
      gnt_q      <= '0;
      cpu_last_q <= 1'b0;
    end else if (reg_en) begin
      state_q    <= state_d;
      gnt_q      <= gnt_d;
      cpu_last_q <= cpu_last_d;
    end
  end

  assign ext_ack_o = gnt_q[IDX_EXT];
  assign int_gnt_o = gnt_q[NUM_MST-1:1];
endmodule

// File: rtl/ebus_arbiter_chk.sv
module ebus_arbiter_chk #(
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ext_req_i,
  input logic             ext_ack_o,
  input logic [2:0]       int_req_i,
  input logic [2:0]       int_gnt_o,
  input logic [2:0]       int_done_i,
  input logic [SEL_W-1:0] gap_sel_i
);
  logic owner_ends;
  assign owner_ends = (|(int_gnt_o & int_done_i)) | (ext_ack_o & ~ext_req_i);

  p_reset_idle_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> ({int_gnt_o, ext_ack_o} == 4'b0000));

  p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({int_gnt_o, ext_ack_o}));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((|{int_gnt_o, ext_ack_o}) && !owner_ends)
      |=> ({int_gnt_o, ext_ack_o} == $past({int_gnt_o, ext_ack_o})));

  p_ext_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_ack_o) |-> $past(ext_req_i));

  p_ext_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_ack_o && ext_req_i) |=> (ext_ack_o && (int_gnt_o == 3'b000)));

  p_cpu_yield_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (int_gnt_o[0] && int_done_i[0] && (|int_req_i[2:1])) |=> !int_gnt_o[0]);

  p_gap_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_ends && (gap_sel_i != '0)) |=> ({int_gnt_o, ext_ack_o} == 4'b0000));

  p_direct_handover_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (int_gnt_o[0] && int_done_i[0] && int_req_i[1] && !int_req_i[2] &&
     !ext_req_i && (gap_sel_i == '0)) |=> int_gnt_o[1]);
endmodule

bind ebus_arbiter ebus_arbiter_chk #(.SEL_W(SEL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ext_req_i  (ext_req_i),
  .ext_ack_o  (ext_ack_o),
  .int_req_i  (int_req_i),
  .int_gnt_o  (int_gnt_o),
  .int_done_i (int_done_i),
  .gap_sel_i  (gap_sel_i)
);

// File: tb/ebus_arbiter_test.sv
module ebus_arbiter_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ext_req_i;
  logic       ext_ack_o;
  logic [2:0] int_req_i;
  logic [2:0] int_gnt_o;
  logic [2:0] int_done_i;
  logic [1:0] gap_sel_i;

  int  checks = 0;
  int  failures = 0;
  bit  finished = 1'b0;

  localparam logic [3:0] G_NONE = 4'b0000;
  localparam logic [3:0] G_EXT  = 4'b0001;
  localparam logic [3:0] G_CPU  = 4'b0010;
  localparam logic [3:0] G_DBG  = 4'b0100;
  localparam logic [3:0] G_DMA  = 4'b1000;

  // {ext_req, int_req[2:0] = {dma,dbg,cpu}, expected {dma,dbg,cpu,ext}}
  localparam int NVEC = 8;
  localparam logic [7:0] VEC [NVEC] = '{
    {1'b0, 3'b001, G_CPU},
    {1'b0, 3'b010, G_DBG},
    {1'b0, 3'b100, G_DMA},
    {1'b0, 3'b011, G_CPU},
    {1'b0, 3'b110, G_DBG},
    {1'b0, 3'b111, G_CPU},
    {1'b1, 3'b111, G_EXT},
    {1'b1, 3'b000, G_EXT}
  };

  ebus_arbiter uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_req_i  (ext_req_i),
    .ext_ack_o  (ext_ack_o),
    .int_req_i  (int_req_i),
    .int_gnt_o  (int_gnt_o),
    .int_done_i (int_done_i),
    .gap_sel_i  (gap_sel_i)
  );

  always #4 clk = ~clk;

  function automatic logic [3:0] grants();
    return {int_gnt_o, ext_ack_o};
  endfunction

  task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  // Pulse done for the given owner bits, with the request vector to leave behind.
  task automatic finish_int(input logic [2:0] owner, input logic [2:0] keep_req);
    int_done_i = owner;
    int_req_i  = keep_req;
    cyc();
    int_done_i = 3'b000;
  endtask

  task automatic gap_case(input logic [1:0] sel, input int exp_len, input string tag);
    int zeros;
    gap_sel_i = sel;
    int_req_i = 3'b001;
    cyc();
    check({tag, " cpu granted"}, grants(), G_CPU);
    int_req_i = 3'b010;
    int_done_i = 3'b001;
    cyc();
    int_done_i = 3'b000;
    zeros = 0;
    for (int k = 0; k < 10; k++) begin
      if (grants() != G_NONE) break;
      zeros++;
      cyc();
    end
    checks++;
    if (zeros != exp_len) begin
      failures++;
      $display("FAIL %s: idle cycles got %0d expected %0d", tag, zeros, exp_len);
    end
    check({tag, " debug after gap"}, grants(), G_DBG);
    gap_sel_i = 2'd0;
    finish_int(3'b010, 3'b000);
    cyc();
  endtask

  initial begin
    rst_n = 1'b0; ext_req_i = 1'b0; int_req_i = '0; int_done_i = '0; gap_sel_i = '0;
    repeat (3) cyc();
    check("R1 grants in reset", grants(), G_NONE);
    rst_n = 1'b1;
    cyc();
    check("R1 grants after reset", grants(), G_NONE);

    // R2 / R5 priority table from an idle bus
    for (int i = 0; i < NVEC; i++) begin
      ext_req_i = VEC[i][7];
      int_req_i = VEC[i][6:4];
      cyc();
      check($sformatf("R2 vector %0d", i), grants(), VEC[i][3:0]);
      ext_req_i = 1'b0;
      if (VEC[i][3:0] == G_EXT) begin
        int_req_i = 3'b000;
        cyc();
      end else begin
        finish_int(VEC[i][3:1], 3'b000);
      end
      check($sformatf("R2 vector %0d released", i), grants(), G_NONE);
    end

    // R4: non-owner done pulses ignored, grant held
    int_req_i = 3'b001;
    cyc();
    int_req_i = 3'b010;
    int_done_i = 3'b110;
    cyc();
    int_done_i = 3'b000;
    check("R4 stray done ignored", grants(), G_CPU);
    repeat (3) cyc();
    check("R4 grant held", grants(), G_CPU);

    // R6 / R9: CPU keeps asking, debug waits; direct handover both ways
    int_req_i = 3'b011;
    finish_int(3'b001, 3'b011);
    check("R6 R9 cpu yields to debug", grants(), G_DBG);
    finish_int(3'b010, 3'b001);
    check("R6 cpu back after debug", grants(), G_CPU);
    finish_int(3'b001, 3'b000);
    cyc();

    // R7: DMA before debug during CPU access
    int_req_i = 3'b001;
    cyc();
    int_req_i = 3'b100;
    cyc();
    int_req_i = 3'b110;
    cyc();
    finish_int(3'b001, 3'b110);
    check("R7 dma first", grants(), G_DMA);
    finish_int(3'b100, 3'b010);
    check("R7 debug after dma", grants(), G_DBG);
    finish_int(3'b010, 3'b000);
    cyc();

    // R7: debug before DMA during CPU access
    int_req_i = 3'b001;
    cyc();
    int_req_i = 3'b010;
    cyc();
    int_req_i = 3'b110;
    cyc();
    finish_int(3'b001, 3'b110);
    check("R7 debug first", grants(), G_DBG);
    finish_int(3'b010, 3'b100);
    check("R7 dma after debug", grants(), G_DMA);
    finish_int(3'b100, 3'b000);
    cyc();

    // R5: off-chip request raised mid-access waits for the boundary
    int_req_i = 3'b001;
    cyc();
    ext_req_i = 1'b1;
    cyc();
    check("R5 no ack mid access", grants(), G_CPU);
    cyc();
    check("R5 still cpu", grants(), G_CPU);
    finish_int(3'b001, 3'b001);
    check("R5 ack at boundary", grants(), G_EXT);
    repeat (3) cyc();
    check("R5 internal held off", grants(), G_EXT);
    ext_req_i = 1'b0;
    cyc();
    check("R5 release to cpu", grants(), G_CPU);
    finish_int(3'b001, 3'b000);
    cyc();

    // R8: idle gap settings
    gap_case(2'd0, 0, "R8 gap0");
    gap_case(2'd1, 1, "R8 gap1");
    gap_case(2'd2, 2, "R8 gap2");
    gap_case(2'd3, 4, "R8 gap3");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule